// File: doc/BRIEF.md
# Testable Binary Ripple Divider (24 Stages)

This block is a synchronous model of a chain of 24 divide-by-two stages. It counts on every falling edge of its input clock while an oscillator enable is high. Only the seven most significant stages (stages 18 through 24) leave the block, so tap Qn runs at the input rate divided by 2^n. An active-high asynchronous reset clears every stage and holds the oscillator-run indication low. While reset is high, no count takes place.

For production test, a mode select splits the chain into three independent 8-stage sections: stages 1-8, 9-16 and 17-24. Each section counts every pulse at once. After reset, 255 pulses in this mode load all ones into every stage. Going back to the series configuration and applying one further pulse then rolls the whole chain to zero. This proves every stage and every carry link in a few hundred cycles instead of 16,777,216.

A small state machine, clocked on the falling edge, sets the configuration. It has four states:
- `ST_HALT`: entered by reset; no counting.
- `ST_IDLE`: the enable is low; the count holds.
- `ST_SERIES`: the chain counts as one 24-bit value.
- `ST_PARALLEL`: three sections, no carry between them.

From any state, reset leads to `ST_HALT`. At each falling edge the machine moves to `ST_IDLE` when the enable is low. Otherwise it moves to `ST_PARALLEL` when the test select is high, or to `ST_SERIES` when it is low. The count performed at an edge is always the one chosen by the state held before that edge.

Top module: `bin_div24`

## Requirements
- R1: While `rst` is high, `taps` reads all zeros and `osc_run` reads 0.
- R2: The first falling edge after reset release only leaves `ST_HALT` and performs no count; `osc_run` goes high after that edge if `osc_en` was high at it.
- R3: In `ST_SERIES` each falling edge adds one to the 24-bit chain value, with carries crossing all sections; `taps[i]` is chain bit 17+i (stage 18+i).
- R4: From a cleared chain in series counting, `taps[0]` (stage 18) first reads 1 after exactly 131,072 counts, so stage n toggles every 2^(n-1) input pulses.
- R5: When `osc_en` is low at a falling edge, the machine enters `ST_IDLE`: `osc_run` is 0 afterwards and the chain holds its value for as long as `osc_en` stays low.
- R6: In `ST_PARALLEL` each 8-bit section (chain bits 0-7, 8-15, 16-23) adds one per falling edge and wraps from 255 to 0 with no carry into the next section.
- R7: `test_sel` and `osc_en` are sampled at a falling edge and take effect from the next falling edge; stage contents are kept across every configuration change.
- R8: After reset, 255 counts in `ST_PARALLEL` set all 24 stages (`taps` = 7'h7F); one further count in `ST_SERIES` returns every stage to 0.
- R9: Raising `rst` clears `taps` and `osc_run` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the count advances on its falling edge |
| rst | input | 1 | Asynchronous active-high reset of all stages and the mode state |
| test_sel | input | 1 | 1 selects the three-section parallel test configuration |
| osc_en | input | 1 | Oscillator enable; counting only while high |
| taps | output | 7 | Stage outputs 18 (bit 0) through 24 (bit 6) |
| osc_run | output | 1 | High while the oscillator runs (state `ST_SERIES` or `ST_PARALLEL`) |

## Verification
Only the top seven stages are visible, so a wrong bit in the lower sections stays hidden in series mode until its carry reaches stage 18. That can take up to 131,072 pulses. The parallel test configuration brings the lower faults forward, because each section fills to all ones within 255 pulses and the series rollover that follows exposes any broken carry link on the very next edge. A wrong state shows within one edge on `osc_run`, or as a tap that fails to change, or changes a cycle late, when the configuration switches.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_HALT     = 2'd0,
        ST_IDLE     = 2'd1,
        ST_SERIES   = 2'd2,
        ST_PARALLEL = 2'd3
    } div_state_e;

endpackage

// File: rtl/div_mode_fsm.sv
module div_mode_fsm
    import div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic osc_en,
    input  logic test_sel,
    output logic count_en,
    output logic par_mode,
    output logic osc_run
);

    div_state_e state_q;
    div_state_e state_d;

    // next configuration from the inputs sampled at this edge
    always_comb begin
        unique case (state_q)
            ST_HALT, ST_IDLE, ST_SERIES, ST_PARALLEL: begin
                if (!osc_en)
                    state_d = ST_IDLE;
                else if (test_sel)
                    state_d = ST_PARALLEL;
                else
                    state_d = ST_SERIES;
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst)
            state_q <= ST_HALT;
        else
            state_q <= state_d;
    end

    always_comb begin
        count_en = 1'b0;
        par_mode = 1'b0;
        unique case (state_q)
            ST_HALT:     count_en = 1'b0;
            ST_IDLE:     count_en = 1'b0;
            ST_SERIES:   count_en = 1'b1;
            ST_PARALLEL: begin
                count_en = 1'b1;
                par_mode = 1'b1;
            end
            default:     count_en = 1'b0;
        endcase
        osc_run = count_en;
    end

    AST_HALT_EXIT: assert property (@(negedge clk) disable iff (rst)
        (state_q == ST_HALT) |=> (state_q != ST_HALT)); // R2

    AST_EN_LOW_STOPS: assert property (@(negedge clk) disable iff (rst)
        !osc_en |=> !osc_run); // R5

    AST_SEL_TAKES_EFFECT: assert property (@(negedge clk) disable iff (rst)
        (osc_en && test_sel) |=> (osc_run && par_mode)); // R7

endmodule

// File: rtl/div_section.sv
module div_section #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         full
);

    always_ff @(negedge clk or posedge rst) begin
        if (rst)
            val <= '0;
        else if (inc)
            val <= val + 1'b1;
    end

    assign full = &val;

    AST_SEC_STEP: assert property (@(negedge clk) disable iff (rst)
        inc |=> (val == W'($past(val) + 1'b1))); // R3

    AST_SEC_HOLD: assert property (@(negedge clk) disable iff (rst)
        !inc |=> $stable(val)); // R5

endmodule

// File: rtl/bin_div24.sv
module bin_div24 #(
    parameter int SECT_W   = 8,
    parameter int NUM_SECT = 3,
    parameter int TAP_LO   = 18
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 test_sel,
    input  logic                                 osc_en,
    output logic [SECT_W*NUM_SECT-TAP_LO:0]      taps,
    output logic                                 osc_run
);

    localparam int CHAIN_W = SECT_W * NUM_SECT;

    logic               count_en;
    logic               par_mode;
    logic [CHAIN_W-1:0] stage;

    div_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .osc_en   (osc_en),
        .test_sel (test_sel),
        .count_en (count_en),
        .par_mode (par_mode),
        .osc_run  (osc_run)
    );

    for (genvar k = 0; k < NUM_SECT; k++) begin : gen_sec
        logic inc_k;
        logic full_k;
        if (k == 0) begin : g_first
            assign inc_k = count_en;
        end else begin : g_chain
            // parallel: every section sees the pulse; series: carry in
            assign inc_k = par_mode ? count_en
                                    : (gen_sec[k-1].inc_k & gen_sec[k-1].full_k);
        end
        div_section #(.W(SECT_W)) u_sec (
            .clk  (clk),
            .rst  (rst),
            .inc  (inc_k),
            .val  (stage[k*SECT_W +: SECT_W]),
            .full (full_k)
        );
    end

    assign taps = stage[CHAIN_W-1:TAP_LO-1];

    always @(negedge clk) begin
        if (rst) begin
            AST_RST_CLEAR: assert (taps == '0 && !osc_run); // R1
        end
    end

    AST_SERIES_ROLL: assert property (@(negedge clk) disable iff (rst)
        (count_en && !par_mode && (&stage)) |=> (stage == '0)); // R8

    AST_PAR_TOP_WRAP: assert property (@(negedge clk) disable iff (rst)
        (count_en && par_mode && (&stage[CHAIN_W-1 -: SECT_W]))
        |=> (stage[CHAIN_W-1 -: SECT_W] == '0)); // R6

endmodule

// File: tb/bin_div24_tb.sv
`timescale 1ns/1ps
module bin_div24_tb;

    logic       clk = 1'b1;
    logic       rst = 1'b0;
    logic       test_sel = 1'b0;
    logic       osc_en = 1'b0;
    logic [6:0] taps;
    logic       osc_run;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference
    int          m_st = 0;      // 0 halt, 1 idle, 2 series, 3 parallel
    logic [23:0] m_cnt = '0;

    always #4 clk = ~clk;

    bin_div24 u_dut (
        .clk      (clk),
        .rst      (rst),
        .test_sel (test_sel),
        .osc_en   (osc_en),
        .taps     (taps),
        .osc_run  (osc_run)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk or posedge rst) begin
        if (rst) begin
            m_st  = 0;
            m_cnt = '0;
        end else begin
            if (m_st == 2)
                m_cnt = m_cnt + 24'd1;
            else if (m_st == 3)
                for (int s = 0; s < 3; s++)
                    m_cnt[s*8 +: 8] = m_cnt[s*8 +: 8] + 8'd1;
            m_st = !osc_en ? 1 : (test_sel ? 3 : 2);
        end
    end

    // every-cycle comparison: R3 series, R6 parallel, R7 mode latency
    always @(posedge clk) begin
        if (cmp_on) begin
            check("R3/R6/R7 taps", {1'b0, taps}, {1'b0, m_cnt[23:17]});
            check("R2/R5 osc_run", {7'b0, osc_run}, {7'b0, (m_st >= 2)});
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(250000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        #1 rst = 1'b1;
        step(3);
        check("R1 taps in reset", {1'b0, taps}, 8'h00);
        check("R1 osc_run in reset", {7'b0, osc_run}, 8'h00);
        cmp_on = 1'b1;

        // parallel fill: R8
        test_sel = 1'b1;
        osc_en   = 1'b1;
        rst      = 1'b0;
        step(1);
        check("R2 run after first edge", {7'b0, osc_run}, 8'h01);
        check("R2 no count on first edge", {1'b0, taps}, 8'h00);
        step(254);
        osc_en   = 1'b0;
        test_sel = 1'b0;
        step(1);
        check("R8 all ones after 255", {1'b0, taps}, 8'h7F);
        check("R5 run low when disabled", {7'b0, osc_run}, 8'h00);
        step(2);
        check("R5 hold while disabled", {1'b0, taps}, 8'h7F);
        osc_en = 1'b1;
        step(1);
        check("R7 contents kept on mode change", {1'b0, taps}, 8'h7F);
        step(1);
        check("R8 series rollover to zero", {1'b0, taps}, 8'h00);

        // mode switching while running, R6/R7 via reference
        step(40);
        test_sel = 1'b1;
        step(300);
        test_sel = 1'b0;
        step(50);
        osc_en = 1'b0;
        step(5);
        osc_en = 1'b1;
        test_sel = 1'b1;
        step(20);

        // long series run: R4
        rst = 1'b1;
        step(2);
        test_sel = 1'b0;
        rst = 1'b0;
        step(131072);
        check("R4 stage 18 still low", {1'b0, taps}, 8'h00);
        step(1);
        check("R4 stage 18 rises", {1'b0, taps}, 8'h01);
        step(10);

        // asynchronous reset mid-count: R9
        rst = 1'b1;
        #1;
        check("R9 async clear taps", {1'b0, taps}, 8'h00);
        check("R9 async clear run", {7'b0, osc_run}, 8'h00);
        step(2);
        rst = 1'b0;
        step(3);

        done = 1'b1;
        finish_run();
    end

endmodule